// File: doc/BRIEF.md
# Oldest-First Ready Instruction Selector

This block decides which instructions waiting in a circular in-flight queue are sent to the functional units in the current cycle. For every queue slot it receives a status snapshot: whether the slot is occupied, whether either source operand is still locked, whether the instruction has already been issued or has finished executing, which unit type it needs, and whether it is a load or a store. It also receives the pointer to the oldest slot and a busy flag for each unit. From these it forms up to `GRANTS` issue slots, ordered from oldest to youngest, and returns a per-entry mark that the queue uses to set the issued flag of each chosen instruction.

Age is measured as the distance from the oldest pointer around the ring, so priority follows the moving head rather than the fixed slot number. Each unit accepts at most one instruction per cycle, and when two candidates need the same unit the older one wins. Memory ordering is applied before selection: a store is only a candidate from the oldest slot, and a load waits while any older store still occupies the queue. The selection is combinational; the clock and reset inputs serve only the embedded property checks.

Top module: `ready_sel`

## Requirements
- R1: An entry is a candidate only when it is occupied, both its source locks are clear, and it is neither issued nor executed.
- R2: An entry whose unit type has its busy bit set in `unit_busy` is never granted.
- R3: Priority is by age, age being (slot index minus `oldest_ptr`) modulo `DEPTH`, so a slot just past the ring wrap is younger than a slot just before it.
- R4: Up to `GRANTS` entries are granted per cycle; if more candidates with distinct units exist, only the oldest ones are granted.
- R5: No two granted slots in the same cycle name the same unit type; of two candidates needing one unit, the older is granted.
- R6: `issue_mark` has exactly one bit set per granted slot, at the granted entry index.
- R7: A store is granted only when its slot index equals `oldest_ptr`.
- R8: A load is not granted while any occupied slot older than it holds a store, whether or not that store has executed.
- R9: Grant slots fill from slot 0 upward in age order; unused slots have valid 0 and zero index and unit fields. Slot s occupies `slot_idx[s*IDX_W +: IDX_W]` and `slot_unit[s*UNIT_W +: UNIT_W]`; entry e's unit code occupies `ent_unit[e*UNIT_W +: UNIT_W]` (default codes 0 and 1 integer, 2 memory, 3 floating point).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for embedded checks |
| rst_n | input | 1 | Active-low reset, disables checks |
| ent_valid | input | DEPTH | Slot holds an in-flight instruction |
| ent_lock_a | input | DEPTH | First source operand still pending |
| ent_lock_b | input | DEPTH | Second source operand still pending |
| ent_issued | input | DEPTH | Instruction already sent to a unit |
| ent_done | input | DEPTH | Instruction has finished executing |
| ent_unit | input | DEPTH*UNIT_W | Unit type code per slot |
| ent_load | input | DEPTH | Slot holds a load |
| ent_store | input | DEPTH | Slot holds a store |
| oldest_ptr | input | IDX_W | Index of the oldest occupied slot |
| unit_busy | input | NUM_UNITS | Per-unit busy flag |
| slot_vld | output | GRANTS | Grant slot carries an instruction |
| slot_idx | output | GRANTS*IDX_W | Queue index (tag) per grant slot |
| slot_unit | output | GRANTS*UNIT_W | Destination unit per grant slot |
| issue_mark | output | DEPTH | Entries to flag as issued |

## Verification
The interesting overlap is between age-ordered slot filling and per-unit conflict resolution: with the oldest pointer near the end of the ring, candidates on both sides of the wrap contend for the same units, so an older entry must both take slot 0 and shut a younger one out of its unit while a still younger entry on another unit takes slot 1. Directed cases place the head at 6 and spread candidates across the wrap, and a broad sweep of random heads, locks, busy flags and load/store mixes is judged against an age-walk model computed in the bench from the requirements, comparing all four outputs at once.

// File: rtl/ready_sel_pkg.sv
package ready_sel_pkg;
   // default configuration of the selector
   localparam int unsigned SEL_DEPTH  = 8;
   localparam int unsigned SEL_GRANTS = 2;
   localparam int unsigned SEL_UNITS  = 4;

   // unit type codes for the default four-unit configuration
   typedef enum logic [1:0] {
      FU_INT_A = 2'd0,
      FU_INT_B = 2'd1,
      FU_MEM   = 2'd2,
      FU_FLT   = 2'd3
   } fu_kind_e;
endpackage

// File: rtl/ready_sel_elig.sv
module ready_sel_elig
   import ready_sel_pkg::*;
#(
   parameter int unsigned DEPTH     = SEL_DEPTH,
   parameter int unsigned NUM_UNITS = SEL_UNITS,
   localparam int unsigned IDX_W    = $clog2(DEPTH),
   localparam int unsigned UNIT_W   = $clog2(NUM_UNITS)
) (
   input  logic [DEPTH-1:0]        valid,
   input  logic [DEPTH-1:0]        lock_a,
   input  logic [DEPTH-1:0]        lock_b,
   input  logic [DEPTH-1:0]        issued,
   input  logic [DEPTH-1:0]        done,
   input  logic [DEPTH*UNIT_W-1:0] unit,
   input  logic [DEPTH-1:0]        is_load,
   input  logic [DEPTH-1:0]        is_store,
   input  logic [IDX_W-1:0]        head,
   input  logic [NUM_UNITS-1:0]    busy,
   output logic [DEPTH-1:0]        elig
);

   // an older store exists for entry i when some occupied store sits
   // closer to the head around the ring
   logic [DEPTH-1:0] older_st;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         older_st[i] = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (valid[j] && is_store[j] &&
                ((IDX_W'(j) - head) < (IDX_W'(i) - head)))
               older_st[i] = 1'b1;
         end
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [UNIT_W-1:0] u_code;
      logic              at_head;
      logic              base_ok;
      logic              mem_ok;

      assign u_code  = unit[i*UNIT_W +: UNIT_W];
      assign at_head = (head == IDX_W'(i));
      assign base_ok = valid[i] & ~lock_a[i] & ~lock_b[i] &
                       ~issued[i] & ~done[i] & ~busy[u_code];
      assign mem_ok  = (~is_store[i] | at_head) & (~is_load[i] | ~older_st[i]);
      assign elig[i] = base_ok & mem_ok;
   end

endmodule

// File: rtl/ready_sel_pick.sv
module ready_sel_pick
   import ready_sel_pkg::*;
#(
   parameter int unsigned DEPTH     = SEL_DEPTH,
   parameter int unsigned GRANTS    = SEL_GRANTS,
   parameter int unsigned NUM_UNITS = SEL_UNITS,
   localparam int unsigned IDX_W    = $clog2(DEPTH),
   localparam int unsigned UNIT_W   = $clog2(NUM_UNITS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DEPTH-1:0]         elig,
   input  logic [DEPTH*UNIT_W-1:0]  unit,
   input  logic [IDX_W-1:0]         head,
   output logic [GRANTS-1:0]        slot_vld,
   output logic [GRANTS*IDX_W-1:0]  slot_idx,
   output logic [GRANTS*UNIT_W-1:0] slot_unit,
   output logic [DEPTH-1:0]         mark
);

   // walk the ring from the head; each candidate takes the next free
   // slot provided its unit has not been claimed by an older entry
   always_comb begin
      int                   n;
      logic [IDX_W-1:0]     idx;
      logic [UNIT_W-1:0]    u_code;
      logic [NUM_UNITS-1:0] taken;

      slot_vld  = '0;
      slot_idx  = '0;
      slot_unit = '0;
      mark      = '0;
      taken     = '0;
      n         = 0;
      for (int k = 0; k < DEPTH; k++) begin
         idx    = head + IDX_W'(k);
         u_code = unit[idx*UNIT_W +: UNIT_W];
         if (elig[idx] && !taken[u_code] && (n < GRANTS)) begin
            slot_vld[n]                    = 1'b1;
            slot_idx[n*IDX_W +: IDX_W]     = idx;
            slot_unit[n*UNIT_W +: UNIT_W]  = u_code;
            mark[idx]                      = 1'b1;
            taken[u_code]                  = 1'b1;
            n                              = n + 1;
         end
      end
   end

   // R6
   mark_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mark) == $countones(slot_vld));

   for (genvar s = 0; s + 1 < GRANTS; s++) begin : g_order
      // R9
      slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
         slot_vld[s+1] |-> slot_vld[s]);
      // R3
      slot_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
         slot_vld[s+1] |->
            ((slot_idx[s*IDX_W +: IDX_W] - head) <
             (slot_idx[(s+1)*IDX_W +: IDX_W] - head)));
   end

   for (genvar a = 0; a < GRANTS; a++) begin : g_ua
      for (genvar b = a + 1; b < GRANTS; b++) begin : g_ub
         // R5
         unit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_vld[a] && slot_vld[b]) |->
               (slot_unit[a*UNIT_W +: UNIT_W] != slot_unit[b*UNIT_W +: UNIT_W]));
      end
   end

endmodule

// File: rtl/ready_sel.sv
module ready_sel
   import ready_sel_pkg::*;
#(
   parameter int unsigned DEPTH     = SEL_DEPTH,
   parameter int unsigned GRANTS    = SEL_GRANTS,
   parameter int unsigned NUM_UNITS = SEL_UNITS,
   localparam int unsigned IDX_W    = $clog2(DEPTH),
   localparam int unsigned UNIT_W   = $clog2(NUM_UNITS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DEPTH-1:0]         ent_valid,
   input  logic [DEPTH-1:0]         ent_lock_a,
   input  logic [DEPTH-1:0]         ent_lock_b,
   input  logic [DEPTH-1:0]         ent_issued,
   input  logic [DEPTH-1:0]         ent_done,
   input  logic [DEPTH*UNIT_W-1:0]  ent_unit,
   input  logic [DEPTH-1:0]         ent_load,
   input  logic [DEPTH-1:0]         ent_store,
   input  logic [IDX_W-1:0]         oldest_ptr,
   input  logic [NUM_UNITS-1:0]     unit_busy,
   output logic [GRANTS-1:0]        slot_vld,
   output logic [GRANTS*IDX_W-1:0]  slot_idx,
   output logic [GRANTS*UNIT_W-1:0] slot_unit,
   output logic [DEPTH-1:0]         issue_mark
);

   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ready_sel: DEPTH must be a power of two, at least 2");
   end
   if (NUM_UNITS < 2 || (NUM_UNITS & (NUM_UNITS - 1)) != 0) begin : g_bad_units
      $error("ready_sel: NUM_UNITS must be a power of two, at least 2");
   end
   if (GRANTS < 1 || GRANTS > NUM_UNITS) begin : g_bad_grants
      $error("ready_sel: GRANTS must lie between 1 and NUM_UNITS");
   end

   logic [DEPTH-1:0] cand;

   ready_sel_elig #(
      .DEPTH     (DEPTH),
      .NUM_UNITS (NUM_UNITS)
   ) u_elig (
      .valid    (ent_valid),
      .lock_a   (ent_lock_a),
      .lock_b   (ent_lock_b),
      .issued   (ent_issued),
      .done     (ent_done),
      .unit     (ent_unit),
      .is_load  (ent_load),
      .is_store (ent_store),
      .head     (oldest_ptr),
      .busy     (unit_busy),
      .elig     (cand)
   );

   ready_sel_pick #(
      .DEPTH     (DEPTH),
      .GRANTS    (GRANTS),
      .NUM_UNITS (NUM_UNITS)
   ) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .elig      (cand),
      .unit      (ent_unit),
      .head      (oldest_ptr),
      .slot_vld  (slot_vld),
      .slot_idx  (slot_idx),
      .slot_unit (slot_unit),
      .mark      (issue_mark)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_chk
      // R1
      issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
         issue_mark[i] |-> (ent_valid[i] && !ent_lock_a[i] && !ent_lock_b[i] &&
                            !ent_issued[i] && !ent_done[i]));
      // R2
      unit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         issue_mark[i] |-> !unit_busy[ent_unit[i*UNIT_W +: UNIT_W]]);
      // R7
      store_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_mark[i] && ent_store[i]) |-> (oldest_ptr == IDX_W'(i)));
      for (genvar j = 0; j < DEPTH; j++) begin : g_pair
         if (i != j) begin : g_ne
            // R8
            load_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
               !(issue_mark[i] && ent_load[i] && ent_valid[j] && ent_store[j] &&
                 ((IDX_W'(j) - oldest_ptr) < (IDX_W'(i) - oldest_ptr))));
         end
      end
   end

endmodule

// File: tb/ready_sel_bench.sv
`timescale 1ns/1ps
module ready_sel_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ent_valid, ent_lock_a, ent_lock_b, ent_issued, ent_done;
   logic [7:0] ent_load, ent_store;
   logic [15:0] ent_unit;
   logic [2:0] oldest_ptr;
   logic [3:0] unit_busy;
   logic [1:0] slot_vld;
   logic [5:0] slot_idx;
   logic [3:0] slot_unit;
   logic [7:0] issue_mark;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   ready_sel u_ready_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .ent_valid  (ent_valid),
      .ent_lock_a (ent_lock_a),
      .ent_lock_b (ent_lock_b),
      .ent_issued (ent_issued),
      .ent_done   (ent_done),
      .ent_unit   (ent_unit),
      .ent_load   (ent_load),
      .ent_store  (ent_store),
      .oldest_ptr (oldest_ptr),
      .unit_busy  (unit_busy),
      .slot_vld   (slot_vld),
      .slot_idx   (slot_idx),
      .slot_unit  (slot_unit),
      .issue_mark (issue_mark)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_in();
      ent_valid = '0; ent_lock_a = '0; ent_lock_b = '0; ent_issued = '0;
      ent_done = '0; ent_load = '0; ent_store = '0; ent_unit = '0;
      oldest_ptr = '0; unit_busy = '0;
   endtask

   task automatic set_unit(input int e, input int u);
      ent_unit[e*2 +: 2] = 2'(u);
   endtask

   task automatic settle();
      @(negedge clk);
      #0.5;
   endtask

   // reference: walk ages from the head, apply rules R1 R2 R7 R8, fill
   // slots in age order R3 R4 R9, one grant per unit R5, mark R6
   task automatic model(output logic [1:0] ev, output logic [5:0] ei,
                        output logic [3:0] eu, output logic [7:0] em);
      int n;
      logic [3:0] used;
      ev = '0; ei = '0; eu = '0; em = '0; used = '0; n = 0;
      for (int k = 0; k < 8; k++) begin
         int e;
         int u;
         bit ok;
         e = (int'(oldest_ptr) + k) % 8;
         u = int'(ent_unit[e*2 +: 2]);
         ok = ent_valid[e] && !ent_lock_a[e] && !ent_lock_b[e] &&
              !ent_issued[e] && !ent_done[e] && !unit_busy[u];
         if (ent_store[e] && k != 0) ok = 0;
         if (ent_load[e])
            for (int m = 0; m < k; m++) begin
               int o;
               o = (int'(oldest_ptr) + m) % 8;
               if (ent_valid[o] && ent_store[o]) ok = 0;
            end
         if (ok && !used[u] && n < 2) begin
            ev[n] = 1'b1;
            ei[n*3 +: 3] = 3'(e);
            eu[n*2 +: 2] = 2'(u);
            em[e] = 1'b1;
            used[u] = 1'b1;
            n++;
         end
      end
   endtask

   initial begin
      #(4.0 * 200000);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [1:0] ev;
      logic [5:0] ei;
      logic [3:0] eu;
      logic [7:0] em;

      clear_in();
      settle();
      // reset state with empty queue: nothing granted (R1, R9)
      chk("R1 reset no grant", 32'(slot_vld), 0);
      chk("R9 reset idx zero", 32'(slot_idx), 0);
      chk("R6 reset mark", 32'(issue_mark), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R1: locked entry is not a candidate, then becomes one
      clear_in(); ent_valid[3] = 1; ent_lock_a[3] = 1; set_unit(3, 1);
      settle();
      chk("R1 locked blocked", 32'(slot_vld), 0);
      ent_lock_a[3] = 0; ent_lock_b[3] = 1;
      settle();
      chk("R1 lock b blocked", 32'(slot_vld), 0);
      ent_lock_b[3] = 0; ent_done[3] = 1;
      settle();
      chk("R1 executed blocked", 32'(slot_vld), 0);
      ent_done[3] = 0;
      settle();
      chk("R1 ready granted", 32'({slot_vld, slot_idx[2:0], slot_unit[1:0]}), 32'({2'b01, 3'd3, 2'd1}));
      chk("R9 unused slot zero", 32'({slot_idx[5:3], slot_unit[3:2]}), 0);

      // R2: busy unit excluded
      clear_in(); ent_valid[1:0] = 2'b11; set_unit(0, 3); set_unit(1, 0); unit_busy[3] = 1;
      settle();
      chk("R2 busy skipped", 32'({slot_vld, slot_idx[2:0]}), 32'({2'b01, 3'd1}));

      // R3: wrap, head at 6; ages 7->1, 1->3, 4->6
      clear_in(); oldest_ptr = 3'd6;
      ent_valid[1] = 1; set_unit(1, 0);
      ent_valid[7] = 1; set_unit(7, 1);
      ent_valid[4] = 1; set_unit(4, 3);
      settle();
      chk("R3 wrap order", 32'({slot_vld, slot_idx}), 32'({2'b11, 3'd1, 3'd7}));
      chk("R6 wrap mark", 32'(issue_mark), 32'h82);

      // R5: same unit, older wins; a different-unit younger fills slot 1
      clear_in();
      ent_valid[2] = 1; set_unit(2, 1);
      ent_valid[5] = 1; set_unit(5, 1);
      ent_valid[6] = 1; set_unit(6, 1);
      settle();
      chk("R5 single grant", 32'({slot_vld, slot_idx[2:0]}), 32'({2'b01, 3'd2}));
      set_unit(6, 0);
      settle();
      chk("R5 younger other unit", 32'({slot_vld, slot_idx}), 32'({2'b11, 3'd6, 3'd2}));

      // R4: four ready on distinct units, only the two oldest go
      clear_in(); ent_valid[3:0] = 4'hf;
      for (int e = 0; e < 4; e++) set_unit(e, e);
      settle();
      chk("R4 limit", 32'({slot_vld, issue_mark}), 32'({2'b11, 8'h03}));

      // R7: store away from head blocked, at head granted
      clear_in(); oldest_ptr = 3'd2;
      ent_valid[2] = 1; ent_lock_a[2] = 1;
      ent_valid[4] = 1; ent_store[4] = 1; set_unit(4, 2);
      settle();
      chk("R7 store not oldest", 32'(slot_vld), 0);
      ent_store[2] = 1; ent_lock_a[2] = 0; set_unit(2, 2);
      settle();
      chk("R7 store at head", 32'({slot_vld, slot_idx[2:0]}), 32'({2'b01, 3'd2}));

      // R8: load behind an older store (even executed) waits
      clear_in();
      ent_valid[1] = 1; ent_store[1] = 1; ent_done[1] = 1; set_unit(1, 2);
      ent_valid[3] = 1; ent_load[3] = 1; set_unit(3, 2);
      settle();
      chk("R8 older store blocks", 32'(slot_vld), 0);
      ent_valid[1] = 0;
      ent_valid[5] = 1; ent_store[5] = 1; set_unit(5, 2);
      settle();
      chk("R8 younger store ok", 32'({slot_vld, slot_idx[2:0], issue_mark}), 32'({2'b01, 3'd3, 8'h08}));

      // broad sweep against the reference (R1 R2 R3 R4 R5 R6 R7 R8 R9)
      for (int t = 0; t < 4000; t++) begin
         ent_valid  = 8'($urandom) | 8'($urandom);
         ent_lock_a = 8'($urandom) & 8'($urandom);
         ent_lock_b = 8'($urandom) & 8'($urandom);
         ent_issued = 8'($urandom) & 8'($urandom) & 8'($urandom);
         ent_done   = 8'($urandom) & 8'($urandom) & 8'($urandom);
         ent_unit   = 16'($urandom);
         ent_store  = 8'($urandom) & 8'($urandom);
         ent_load   = 8'($urandom) & ~ent_store;
         oldest_ptr = 3'($urandom);
         unit_busy  = 4'($urandom) & 4'($urandom);
         settle();
         model(ev, ei, eu, em);
         chk("R3 R4 R5 R6 R9 sweep", 32'({slot_vld, slot_idx, slot_unit, issue_mark}),
             32'({ev, ei, eu, em}));
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule